// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block sends bytes on one asynchronous serial output line. The host writes a byte into a holding register through a simple register-write strobe. A separate shift register moves the byte onto the line. Each frame is non-return-to-zero: a low start bit, then eight data bits with the least significant bit first, an optional ninth data bit, and a high stop bit. Because there are two registers, the host can queue the next byte while the current frame is still on the line. The shift register takes that byte one cycle after the stop bit of the running frame has ended.

The bit period comes from an 8-bit divider value N. The divider divides the input clock by N+1, and a prescale then divides its output by 16 or by 64. The host sees three things. A sticky buffer-empty flag tells it when to write the next byte. An interrupt output is that flag gated by a mask bit. A shift-empty status bit is high while no frame is in progress. The buffer-empty flag clears one cycle after a write, not at once. Clearing transmit enable or port enable stops the line at high and drops any frame in progress.

Top module: `dbuf_serial_tx`

## Requirements
- R1: After reset, `txLine` is 1, `bufEmpty` is 0, `intReq` is 0 and `shiftEmpty` is 1.
- R2: A frame is a start bit of 0, then data bits 0 to 7 with bit 0 first, then a stop bit of 1. Host writes to address 2 put data into the holding register.
- R3: When configuration bit 2 (address 0) is 1, configuration bit 5 is sent as a ninth data bit between data bit 7 and the stop bit. No parity is computed.
- R4: Each bit lasts (N+1)*16 clocks when configuration bit 3 is 1, and (N+1)*64 clocks when it is 0. N is the byte last written to address 1.
- R5: When the shifter is idle and the port is active, a holding write at edge k loads the shifter at edge k+1. From then on `txLine` shows the start bit and `shiftEmpty` is 0. `shiftEmpty` returns to 1 at the edge that ends the stop bit.
- R6: A byte written while a frame is running is loaded only after that frame's stop bit ends, one clock after `shiftEmpty` rises. During that idle clock the line is high.
- R7: Every load sets `bufEmpty`. After a holding write at edge k, `bufEmpty` keeps its old value until edge k+1, and only then clears (unless a load sets it at that edge).
- R8: A configuration write that changes bit 1 (transmit enable) from 0 to 1 sets `bufEmpty` at that edge.
- R9: `intReq` is 1 exactly when `bufEmpty` is 1 and configuration bit 4 (interrupt mask) is 1.
- R10: The port is active only when configuration bit 0 (port enable) and bit 1 (transmit enable) are both 1. While it is inactive, `txLine` is 1 and no frame starts. Making the port inactive drops any running frame, so `shiftEmpty` is 1 one edge later. The holding register keeps its content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register address: 0 config, 1 divider, 2 holding data |
| wrData | input | 8 | Write data |
| txLine | output | 1 | Serial output, idles high |
| bufEmpty | output | 1 | Holding register empty flag |
| intReq | output | 1 | Masked buffer-empty interrupt |
| shiftEmpty | output | 1 | No frame in progress |

## Verification
The hardest state to reach from the ports is the one-cycle window in which the buffer-empty flag still shows 1 after a write. This window can only be seen while the shifter is busy, because an idle shifter reloads at once and sets the flag again. The stimulus therefore starts one frame, writes a second byte during it, and samples the flag on the next two clocks. It then follows the handover that comes at the end of the stop bit. A second hard case is restarting the transmitter while a byte is still queued: the stimulus disables the port in mid-frame and then enables it again. This shows that the frame is dropped, that the flag is set again, and that the queued byte is still sent afterwards.

// File: rtl/dbuf_tx_pkg.sv
package dbuf_tx_pkg;
  localparam logic [1:0] ADDR_CFG  = 2'd0;
  localparam logic [1:0] ADDR_DIV  = 2'd1;
  localparam logic [1:0] ADDR_HOLD = 2'd2;

  typedef struct packed {
    logic ninth;
    logic intEn;
    logic highSpeed;
    logic nineBit;
    logic txEn;
    logic portEn;
  } txCfg_t;

  typedef struct packed {
    logic load;
    logic shift;
  } txStrobe_t;
endpackage

// File: rtl/dbuf_tx_dpath.sv
module dbuf_tx_dpath
  import dbuf_tx_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int DIV_W    = 8,
  parameter int FAST_PRE = 16,
  parameter int SLOW_PRE = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfgWr,
  input  logic              divWr,
  input  logic              holdWr,
  input  logic [DATA_W-1:0] wrData,
  input  txStrobe_t         stb,
  output txCfg_t            cfg,
  output logic              holdFull,
  output logic              bitTick,
  output logic              lineBit
);
  localparam int SH_W  = DATA_W + 3;
  localparam int PRE_W = $clog2(SLOW_PRE);

  logic [DATA_W-1:0] holdReg;
  logic [DIV_W-1:0]  divVal, divCnt;
  logic [PRE_W-1:0]  preCnt, preLast;
  logic [SH_W-1:0]   shReg;
  logic              divTick;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg      <= '0;
      divVal   <= '0;
      holdReg  <= '0;
      holdFull <= 1'b0;
    end else begin
      if (cfgWr) cfg <= txCfg_t'(wrData[5:0]);
      if (divWr) divVal <= wrData[DIV_W-1:0];
      if (holdWr) begin
        holdReg  <= wrData;
        holdFull <= 1'b1;
      end else if (stb.load) begin
        holdFull <= 1'b0;
      end
    end
  end

  // baud divider: N down to 0, restarts on a frame load or a divider write
  assign divTick = (divCnt == '0) && !stb.load && !divWr;
  assign preLast = cfg.highSpeed ? PRE_W'(FAST_PRE - 1) : PRE_W'(SLOW_PRE - 1);
  assign bitTick = divTick && (preCnt == preLast);

  always_ff @(posedge clk) begin
    if (rst) begin
      divCnt <= '0;
      preCnt <= '0;
    end else begin
      if (divWr)              divCnt <= wrData[DIV_W-1:0];
      else if (stb.load)      divCnt <= divVal;
      else if (divCnt == '0)  divCnt <= divVal;
      else                    divCnt <= divCnt - 1'b1;

      if (stb.load)           preCnt <= '0;
      else if (divTick)       preCnt <= (preCnt == preLast) ? '0 : preCnt + 1'b1;
    end
  end

  // frame image: stop, ninth (or stop filler), data, start
  always_ff @(posedge clk) begin
    if (rst) begin
      shReg <= '1;
    end else if (stb.load) begin
      shReg <= {1'b1, (cfg.nineBit ? cfg.ninth : 1'b1), holdReg, 1'b0};
    end else if (stb.shift) begin
      shReg <= {1'b1, shReg[SH_W-1:1]};
    end
  end

  assign lineBit = shReg[0];
endmodule

// File: rtl/dbuf_tx_ctrl.sv
module dbuf_tx_ctrl
  import dbuf_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic      clk,
  input  logic      rst,
  input  txCfg_t    cfg,
  input  logic      cfgWr,
  input  logic      wrTxEn,
  input  logic      holdWr,
  input  logic      holdFull,
  input  logic      bitTick,
  output txStrobe_t stb,
  output logic      busy,
  output logic      flag
);
  localparam int IDX_W = $clog2(DATA_W + 3);
  localparam logic [IDX_W-1:0] LAST_SHORT = IDX_W'(DATA_W + 1);
  localparam logic [IDX_W-1:0] LAST_LONG  = IDX_W'(DATA_W + 2);

  logic             active, txEnSet, wrPend, lastBit;
  logic [IDX_W-1:0] bitIdx;

  assign active    = cfg.portEn && cfg.txEn;
  assign txEnSet   = cfgWr && wrTxEn && !cfg.txEn;
  assign lastBit   = bitIdx == (cfg.nineBit ? LAST_LONG : LAST_SHORT);
  assign stb.load  = active && !busy && holdFull;
  assign stb.shift = busy && bitTick;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      bitIdx <= '0;
    end else if (!active) begin
      busy   <= 1'b0;
      bitIdx <= '0;
    end else if (stb.load) begin
      busy   <= 1'b1;
      bitIdx <= '0;
    end else if (stb.shift) begin
      if (lastBit) busy <= 1'b0;
      bitIdx <= lastBit ? '0 : bitIdx + 1'b1;
    end
  end

  // buffer-empty flag: set by load or enable, cleared one cycle after a write
  always_ff @(posedge clk) begin
    if (rst) begin
      wrPend <= 1'b0;
      flag   <= 1'b0;
    end else begin
      wrPend <= holdWr;
      if (txEnSet || stb.load) flag <= 1'b1;
      else if (wrPend)         flag <= 1'b0;
    end
  end
endmodule

// File: rtl/dbuf_serial_tx.sv
module dbuf_serial_tx
  import dbuf_tx_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int DIV_W    = 8,
  parameter int FAST_PRE = 16,
  parameter int SLOW_PRE = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              txLine,
  output logic              bufEmpty,
  output logic              intReq,
  output logic              shiftEmpty
);
  txCfg_t    cfgW;
  txStrobe_t stbW;
  logic      cfgWr, divWr, holdWr, holdFullW, bitTickW, lineBitW, busyW, flagW, activeW;

  assign cfgWr  = wrEn && (wrAddr == ADDR_CFG);
  assign divWr  = wrEn && (wrAddr == ADDR_DIV);
  assign holdWr = wrEn && (wrAddr == ADDR_HOLD);

  dbuf_tx_dpath #(
    .DATA_W(DATA_W), .DIV_W(DIV_W), .FAST_PRE(FAST_PRE), .SLOW_PRE(SLOW_PRE)
  ) u_dpath (
    .clk(clk), .rst(rst), .cfgWr(cfgWr), .divWr(divWr), .holdWr(holdWr),
    .wrData(wrData), .stb(stbW), .cfg(cfgW), .holdFull(holdFullW),
    .bitTick(bitTickW), .lineBit(lineBitW)
  );

  dbuf_tx_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst), .cfg(cfgW), .cfgWr(cfgWr), .wrTxEn(wrData[1]),
    .holdWr(holdWr), .holdFull(holdFullW), .bitTick(bitTickW),
    .stb(stbW), .busy(busyW), .flag(flagW)
  );

  assign activeW    = cfgW.portEn && cfgW.txEn;
  assign txLine     = (activeW && busyW) ? lineBitW : 1'b1;
  assign bufEmpty   = flagW;
  assign intReq     = flagW && cfgW.intEn;
  assign shiftEmpty = !busyW;
endmodule

// File: rtl/dbuf_tx_chk.sv
module dbuf_tx_chk (
  input logic clk,
  input logic rst,
  input logic active,
  input logic txLine,
  input logic shiftEmpty,
  input logic bufEmpty,
  input logic intReq
);
  p_irq_needs_flag_r9: assert property (@(posedge clk) disable iff (rst)
    intReq |-> bufEmpty);

  p_inactive_line_high_r10: assert property (@(posedge clk) disable iff (rst)
    !active |-> txLine);

  p_inactive_empties_r10: assert property (@(posedge clk) disable iff (rst)
    !active |=> shiftEmpty);

  p_start_low_r2: assert property (@(posedge clk) disable iff (rst)
    ($fell(shiftEmpty) && active) |-> !txLine);

  p_load_sets_flag_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(shiftEmpty) |-> bufEmpty);
endmodule

bind dbuf_serial_tx dbuf_tx_chk u_chk (
  .clk(clk), .rst(rst), .active(activeW), .txLine(txLine),
  .shiftEmpty(shiftEmpty), .bufEmpty(bufEmpty), .intReq(intReq)
);

// File: tb/tb_dbuf_serial_tx.sv
module tb_dbuf_serial_tx;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = 2'd0;
  logic [7:0] wrData = 8'd0;
  logic       txLine, bufEmpty, intReq, shiftEmpty;
  int         checks = 0;
  int         errors = 0;

  always #4 clk = ~clk;

  dbuf_serial_tx dut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .txLine(txLine), .bufEmpty(bufEmpty), .intReq(intReq), .shiftEmpty(shiftEmpty)
  );

  // vector: data[18:11] nine[10] ninth[9] highSpeed[8] div[7:0]
  localparam logic [18:0] VEC [6] = '{
    {8'hA5, 1'b0, 1'b0, 1'b1, 8'd0},
    {8'h3C, 1'b1, 1'b1, 1'b1, 8'd1},
    {8'h81, 1'b1, 1'b0, 1'b1, 8'd2},
    {8'hFF, 1'b0, 1'b0, 1'b0, 8'd0},
    {8'h00, 1'b1, 1'b1, 1'b1, 8'd0},
    {8'h6E, 1'b0, 1'b0, 1'b1, 8'd3}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] cfgByte(input logic pe, te, nine, hs, ie, ninth);
    return {2'b00, ninth, ie, hs, nine, te, pe};
  endfunction

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // entered half a cycle after the load edge
  task automatic checkFrame(input logic [7:0] d, input logic nine, input logic ninth, input int per);
    int nb;
    logic e;
    nb = nine ? 11 : 10;
    chk("R5 start after load", {15'd0, txLine}, 16'd0);
    chk("R5 shiftEmpty low in frame", {15'd0, shiftEmpty}, 16'd0);
    chk("R7 load sets flag", {15'd0, bufEmpty}, 16'd1);
    repeat (per - 1) @(negedge clk);
    chk("R4 start bit end", {15'd0, txLine}, 16'd0);
    @(negedge clk);
    chk("R4 first data bit begins", {15'd0, txLine}, {15'd0, d[0]});
    repeat (per / 2) @(negedge clk);
    for (int j = 1; j < nb; j++) begin
      if (j > 1) repeat (per) @(negedge clk);
      if (j <= 8) e = d[j-1];
      else if (j == 9 && nine) e = ninth;
      else e = 1'b1;
      if (j == 9 && nine) chk("R3 ninth bit", {15'd0, txLine}, {15'd0, e});
      else chk("R2 frame bit", {15'd0, txLine}, {15'd0, e});
    end
    repeat (per / 2) @(negedge clk);
    chk("R5 shiftEmpty after stop", {15'd0, shiftEmpty}, 16'd1);
  endtask

  task automatic sendFrame(input logic [7:0] d, input logic nine, input logic ninth, input int per);
    regWrite(2'd2, d);
    chk("R5 not loaded on write edge", {15'd0, shiftEmpty}, 16'd1);
    @(negedge clk);
    checkFrame(d, nine, ninth, per);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int per;
    logic [18:0] v;
    int bad;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 txLine", {15'd0, txLine}, 16'd1);
    chk("R1 bufEmpty", {15'd0, bufEmpty}, 16'd0);
    chk("R1 intReq", {15'd0, intReq}, 16'd0);
    chk("R1 shiftEmpty", {15'd0, shiftEmpty}, 16'd1);

    // R8 enabling sets flag; R9 mask
    regWrite(2'd0, cfgByte(1, 1, 0, 1, 0, 0));
    chk("R8 enable sets flag", {15'd0, bufEmpty}, 16'd1);
    chk("R9 masked", {15'd0, intReq}, 16'd0);
    regWrite(2'd0, cfgByte(1, 1, 0, 1, 1, 0));
    chk("R9 unmasked", {15'd0, intReq}, 16'd1);

    // vector table: formats and bit periods
    foreach (VEC[i]) begin
      v = VEC[i];
      regWrite(2'd0, cfgByte(1, 1, v[10], v[8], 1, v[9]));
      regWrite(2'd1, v[7:0]);
      per = (int'(v[7:0]) + 1) * (v[8] ? 16 : 64);
      sendFrame(v[18:11], v[10], v[9], per);
    end

    // R6/R7 back-to-back with late flag clear
    regWrite(2'd0, cfgByte(1, 1, 0, 1, 1, 0));
    regWrite(2'd1, 8'd0);
    regWrite(2'd2, 8'h5A);
    @(negedge clk);
    regWrite(2'd2, 8'hC3);
    chk("R7 flag old value after write", {15'd0, bufEmpty}, 16'd1);
    chk("R9 irq follows flag", {15'd0, intReq}, 16'd1);
    @(negedge clk);
    chk("R7 flag cleared second cycle", {15'd0, bufEmpty}, 16'd0);
    chk("R9 irq low with flag", {15'd0, intReq}, 16'd0);
    repeat (10 * 16 - 3) @(negedge clk);
    chk("R6 shifter idle after stop", {15'd0, shiftEmpty}, 16'd1);
    chk("R6 idle clock high", {15'd0, txLine}, 16'd1);
    chk("R6 no load before stop ends", {15'd0, bufEmpty}, 16'd0);
    @(negedge clk);
    checkFrame(8'hC3, 1'b0, 1'b0, 16);

    // R10 abort and R8 re-enable with a queued byte
    regWrite(2'd2, 8'h96);
    @(negedge clk);
    regWrite(2'd2, 8'h47);
    repeat (20) @(negedge clk);
    chk("R7 flag low while queued", {15'd0, bufEmpty}, 16'd0);
    regWrite(2'd0, cfgByte(1, 0, 0, 1, 1, 0));
    chk("R10 line high when disabled", {15'd0, txLine}, 16'd1);
    @(negedge clk);
    chk("R10 frame dropped", {15'd0, shiftEmpty}, 16'd1);
    chk("R10 flag unchanged by disable", {15'd0, bufEmpty}, 16'd0);
    regWrite(2'd0, cfgByte(1, 1, 0, 1, 1, 0));
    chk("R8 re-enable sets flag", {15'd0, bufEmpty}, 16'd1);
    @(negedge clk);
    checkFrame(8'h47, 1'b0, 1'b0, 16);

    // R10 port enable low blocks transmission
    regWrite(2'd0, cfgByte(0, 1, 0, 1, 1, 0));
    regWrite(2'd2, 8'h33);
    bad = 0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (txLine !== 1'b1 || shiftEmpty !== 1'b1) bad++;
    end
    chk("R10 no frame while port off", bad[15:0], 16'd0);
    regWrite(2'd0, cfgByte(1, 1, 0, 1, 1, 0));
    chk("R10 held byte kept", {15'd0, shiftEmpty}, 16'd1);
    @(negedge clk);
    checkFrame(8'h33, 1'b0, 1'b0, 16);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule